// File: doc/BRIEF.md
# Binary-Input Weighted Threshold Neuron

This block is a single neuron built only from gates. It has four one-bit inputs. Each input selects its own unsigned 2-bit weight: when the input is 1 the weight is added to a running total, and when it is 0 the weight contributes nothing. The total can range from 0 to 12. It is compared with a threshold that is programmed as a 2-bit code, where the threshold value is the code plus one, so from 1 to 4. A fire bit goes high when the total reaches or exceeds that threshold.

The inputs, weights and code are packed into two 8-bit input ports. One 8-bit output port carries the fire bit and the 4-bit total, which is exposed for debug. The block has no storage, so its outputs follow its inputs without waiting for any clock edge. A clock and an active-low reset are present on the port list for the surrounding harness, but the logic does not use them. The bidirectional pad controls are held off, so the second port acts only as an input.

Top module: `wtn_neuron`

## Requirements
- R1: Input xi is `sense_a[i]` for i = 0..3. Weight 0 is `sense_a[5:4]`, weight 1 is `sense_a[7:6]`, weight 2 is `sense_b[1:0]` and weight 3 is `sense_b[3:2]`. Each weight is an unsigned value from 0 to 3.
- R2: `drive_q[4:1]` equals x0*w0 + x1*w1 + x2*w2 + x3*w3, as an unsigned value from 0 to 12.
- R3: `drive_q[0]` is 1 exactly when the sum is at least `sense_b[5:4]` + 1. The comparison is made at 4-bit width, so a code of 3 means a threshold of 4, and sums from 5 to 12 fire for every code.
- R4: When `sense_a[3:0]` is 0, `drive_q[0]` is 0 for every weight and code.
- R5: `drive_q[7:5]` is always 0.
- R6: `bidir_q` and `bidir_oe` are always all zero.
- R7: `sense_b[7:6]`, `clk` and `rst_n` have no effect on `drive_q`.
- R8: With all weights at 1 and code 0, `drive_q[0]` is the OR of the four inputs. With all weights at 1 and code 3, `drive_q[0]` is their AND.
- R9: The outputs settle after an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Harness clock, unused by the logic |
| rst_n | input | 1 | Harness active-low reset, unused by the logic |
| sense_a | input | 8 | Inputs x0..x3 on [3:0], weight 0 on [5:4], weight 1 on [7:6] |
| sense_b | input | 8 | Weight 2 on [1:0], weight 3 on [3:2], threshold code on [5:4], [7:6] ignored |
| drive_q | output | 8 | Fire bit on [0], sum on [4:1], [7:5] zero |
| bidir_q | output | 8 | Bidirectional data out, tied to zero |
| bidir_oe | output | 8 | Bidirectional output enables, tied to zero |

## Verification
The hardest cases to reach are the edges of the comparison. One is a sum exactly equal to the threshold. The other is the top code, whose threshold of 4 would wrap to 0 if the comparison were made at 2 bits. Both appear only for particular combinations of active inputs and weight values. Directed cases place the sum at the threshold minus one, at the threshold, and at the maximum of 12 for each code. An exhaustive sweep of all 16384 settings of the fourteen live input bits then checks every combination against a reference model. The sweep is repeated with the ignored bits flipped.

// File: rtl/wtn_neuron.sv
module wtn_neuron #(
  parameter int N_IN   = 4,
  parameter int W_BITS = 2,
  parameter int T_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sense_a,
  input  logic [7:0] sense_b,
  output logic [7:0] drive_q,
  output logic [7:0] bidir_q,
  output logic [7:0] bidir_oe
);
  localparam int S_BITS = 4;

  logic [N_IN-1:0]   x_vec;
  logic [W_BITS-1:0] wgt [N_IN];
  logic [S_BITS-1:0] gated [N_IN];
  logic [S_BITS-1:0] total;
  logic [T_BITS-1:0] th_code;
  logic [S_BITS-1:0] th_val;
  logic              fire;
  logic              unused_pins;

  assign x_vec   = sense_a[N_IN-1:0];
  assign wgt[0]  = sense_a[5:4];
  assign wgt[1]  = sense_a[7:6];
  assign wgt[2]  = sense_b[1:0];
  assign wgt[3]  = sense_b[3:2];
  assign th_code = sense_b[5:4];

  for (genvar i = 0; i < N_IN; i++) begin : g_gate
    assign gated[i] = x_vec[i] ? S_BITS'(wgt[i]) : '0;
  end

  assign total  = (gated[0] + gated[1]) + (gated[2] + gated[3]);
  assign th_val = S_BITS'(th_code) + S_BITS'(1);
  assign fire   = (total >= th_val);

  assign drive_q  = {3'b000, total, fire};
  assign bidir_q  = '0;
  assign bidir_oe = '0;

  assign unused_pins = &{1'b0, sense_b[7:6], clk, rst_n};

  p_sum_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q[4:1] <= 4'd12);

  p_fire_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q[0] == (drive_q[4:1] > {2'b00, sense_b[5:4]}));

  p_zero_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_a[3:0] == 4'b0000) |-> !drive_q[0]);

  p_zero_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_a[3:0] == 4'b0000) |-> (drive_q[4:1] == 4'd0));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_q[7:5] == 3'b000);

  p_bidir_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bidir_q == 8'h00) && (bidir_oe == 8'h00));
endmodule

// File: tb/sim_wtn_neuron.sv
module sim_wtn_neuron;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sense_a = '0;
  logic [7:0] sense_b = '0;
  logic [7:0] drive_q;
  logic [7:0] bidir_q;
  logic [7:0] bidir_oe;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  wtn_neuron u0 (.clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
                 .drive_q(drive_q), .bidir_q(bidir_q), .bidir_oe(bidir_oe));

  always #10 clk = ~clk;

  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = (a[0] ? int'(a[5:4]) : 0) + (a[1] ? int'(a[7:6]) : 0)
      + (a[2] ? int'(b[1:0]) : 0) + (a[3] ? int'(b[3:2]) : 0);
    return {3'b000, 4'(s), (s >= int'(b[5:4]) + 1)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: a=%h b=%h actual=%h expected=%h", req, sense_a, sense_b, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    sense_a = a;
    sense_b = b;
    #2;
  endtask

  function automatic logic [7:0] pack_a(input logic [3:0] x, input logic [1:0] w0, input logic [1:0] w1);
    return {w1, w0, x};
  endfunction

  function automatic logic [7:0] pack_b(input logic [1:0] w2, input logic [1:0] w3, input logic [1:0] c);
    return {2'b00, c, w3, w2};
  endfunction

  task automatic t_reset_state;
    apply(8'h00, 8'h00);
    check("R5 reset", drive_q, 8'h00);
    check("R6 reset", {bidir_q | bidir_oe}, 8'h00);
  endtask

  task automatic t_zero_inputs;
    for (int w = 0; w < 256; w++) begin
      apply({w[3:0], 4'b0000}, {2'b00, w[7:4], w[1:0]});
      check("R4 zero inputs", {7'b0, drive_q[0]}, 8'h00);
    end
  endtask

  task automatic t_or_and;
    for (int x = 0; x < 16; x++) begin
      apply(pack_a(4'(x), 2'd1, 2'd1), pack_b(2'd1, 2'd1, 2'd0));
      check("R8 or", {7'b0, drive_q[0]}, {7'b0, |4'(x)});
      apply(pack_a(4'(x), 2'd1, 2'd1), pack_b(2'd1, 2'd1, 2'd3));
      check("R8 and", {7'b0, drive_q[0]}, {7'b0, &4'(x)});
    end
  endtask

  task automatic t_field_map;
    apply(pack_a(4'b0001, 2'd3, 2'd0), pack_b(2'd0, 2'd0, 2'd0));
    check("R1 w0", drive_q, {3'b0, 4'd3, 1'b1});
    apply(pack_a(4'b0010, 2'd0, 2'd2), pack_b(2'd0, 2'd0, 2'd0));
    check("R1 w1", drive_q, {3'b0, 4'd2, 1'b1});
    apply(pack_a(4'b0100, 2'd0, 2'd0), pack_b(2'd1, 2'd0, 2'd1));
    check("R1 w2", drive_q, {3'b0, 4'd1, 1'b0});
    apply(pack_a(4'b1000, 2'd0, 2'd0), pack_b(2'd0, 2'd3, 2'd2));
    check("R1 w3", drive_q, {3'b0, 4'd3, 1'b1});
    apply(pack_a(4'b1111, 2'd3, 2'd3), pack_b(2'd3, 2'd3, 2'd3));
    check("R2 max sum", drive_q, {3'b0, 4'd12, 1'b1});
    apply(pack_a(4'b0101, 2'd2, 2'd3), pack_b(2'd3, 2'd1, 2'd3));
    check("R2 partial", drive_q, {3'b0, 4'd5, 1'b1});
  endtask

  task automatic t_threshold_edges;
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s <= 12; s++) begin
        logic [1:0] w [4];
        int rem = s;
        for (int k = 0; k < 4; k++) begin
          w[k] = (rem >= 3) ? 2'd3 : 2'(rem);
          rem -= int'(w[k]);
        end
        apply(pack_a(4'hF, w[0], w[1]), pack_b(w[2], w[3], 2'(c)));
        check("R3 threshold", drive_q, {3'b0, 4'(s), (s >= c + 1)});
      end
    end
  endtask

  task automatic t_exhaustive;
    for (int v = 0; v < 16384; v++) begin
      logic [7:0] a = v[7:0];
      logic [7:0] b = {2'b00, v[13:8]};
      logic [7:0] q0;
      apply(a, b);
      check("R2 R3 sweep", drive_q, model(a, b));
      q0 = drive_q;
      sense_b[7:6] = 2'(v % 3 + 1);
      #1;
      check("R7 ignored bits", drive_q, q0);
      check("R6 sweep", {bidir_q | bidir_oe}, 8'h00);
    end
  endtask

  task automatic t_no_clock;
    @(posedge clk);
    #1;
    sense_a = pack_a(4'b0011, 2'd2, 2'd2);
    sense_b = pack_b(2'd0, 2'd0, 2'd3);
    #2;
    check("R9 no edge", drive_q, {3'b0, 4'd4, 1'b1});
    sense_a[1] = 1'b0;
    #2;
    check("R9 no edge drop", drive_q, {3'b0, 4'd2, 1'b0});
  endtask

  task automatic t_clk_rst_ignored;
    apply(pack_a(4'b1010, 2'd0, 2'd3), pack_b(2'd0, 2'd2, 2'd2));
    rst_n = 1'b0;
    #1;
    check("R7 rst_n ignored", drive_q, {3'b0, 4'd5, 1'b1});
    rst_n = 1'b1;
  endtask

  initial begin
    #15;
    t_reset_state();
    rst_n = 1'b1;
    t_zero_inputs();
    t_or_and();
    t_field_map();
    t_threshold_edges();
    t_no_clock();
    t_clk_rst_ignored();
    t_exhaustive();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule